// File: doc/BRIEF.md
# Address Region Attribute Matcher

This block keeps a small table of memory-area descriptors and, for each 32-bit address presented on its lookup port, returns three resolved attribute flags: global, immediate and immediate-without-freeze. Each descriptor holds a 24-bit base field, which stores address bits [31:8], and a separate attribute word. The area's size is not kept in a separate mask. It is encoded by a marker bit: the lowest set bit of the base field's ten least significant bits. An extra size-range bit selects a larger family of sizes.

Every enabled area is compared against the address in parallel. The attributes of all matching normal areas are merged. Any matching area whose reverse flag is set then removes the attributes it marks. A reverse area placed inside a larger normal area therefore cuts a hole in that area's attributes. Software sets up the table through a simple register write port and reads it back through a registered read port. The lookup result is registered and carries a valid flag.

Top module: `region_attr_matcher`

## Requirements
- R1: Each area has a base register at register address {index, 0}. A write stores wdata[31:8] as the 24-bit base field. Bits [7:0] of a write are ignored, and those bits always read back as zero. Read data appears on reg_rdata one cycle after reg_addr is presented.
- R2: When the size-range bit is 0 and k is the lowest set bit of base field bits [9:0], the area spans 2^(9+k) bytes. An address hits when its bits above that span equal the base address. A 256 KB area at 1 MB is written with field 0x001200 and covers 0x100000 to 0x13FFFF.
- R3: When the size-range bit is 1, the same marker k gives an area of 2^(19+k) bytes. Base field bits [9:0] then serve only as the size code.
- R4: An area whose base field bits [9:0] are all zero never hits. An area with the size-range bit set is also unsupported, and never hits, when any base address bit from bit 18 up to the bottom of its span is set.
- R5: An area whose enable bit is 0 never hits. An address that hits no enabled area resolves to all three attributes cleared.
- R6: When several matching areas have their reverse bit clear, their attributes are ORed together. An area may be global and immediate at the same time.
- R7: A matching area with its reverse bit set clears each attribute it has set. This step is applied after all normal areas, so it takes priority over them regardless of descriptor index.
- R8: The global, immediate and no-freeze attributes resolve independently of one another.
- R9: A lookup issued with lk_valid high gives its result and res_valid high on the next clock. In any cycle after one without a lookup, res_valid is low and the attribute outputs hold their previous values.
- R10: A register write changes only lookups issued in later cycles. A lookup issued in the same cycle as the write sees the old table.
- R11: Each area has an attribute register at register address {index, 1}. Its bit fields are: [0] size-range, [1] enable, [2] global, [3] immediate, [4] no-freeze, [5] reverse. Bits [31:6] are ignored on write and read back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | $clog2(NUM_AREAS)+1 | Register address {area index, register select} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's reg_addr |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Address to classify |
| res_valid | output | 1 | Result valid, one cycle after lk_valid |
| res_glb | output | 1 | Resolved global attribute |
| res_imm | output | 1 | Resolved immediate attribute |
| res_nofreeze | output | 1 | Resolved immediate-without-freeze attribute |

## Verification
A corrupted descriptor field or a wrong size decode shows up on the very next lookup as a wrong attribute. The error appears exactly at the span edges, so the bench sweeps addresses on both sides of every edge at 4 KB granularity. It compares each result against an arithmetic model that uses division and remainder. A bad merge order shows as a hole that is missing or inverted in the nested-area configuration. A stale or early table update shows in the one cycle straddling a write. A register holding a wrong value shows on readback one cycle after the address is presented.

// File: rtl/ram_pkg.sv
package ram_pkg;
  localparam int ADDR_W   = 32;
  localparam int BASE_LSB = 8;
  localparam int FIELD_W  = ADDR_W - BASE_LSB;
  localparam int SIZE_W   = 10;
  localparam int ATTR_W   = 6;

  typedef struct packed {
    logic reverse;
    logic nofreeze;
    logic imm;
    logic glb;
    logic enable;
    logic size_hi;
  } area_attr_t;

  typedef struct packed {
    logic nofreeze;
    logic imm;
    logic glb;
  } attr_res_t;
endpackage

// File: rtl/ram_area_match.sv
module ram_area_match
  import ram_pkg::*;
(
  input  logic [FIELD_W-1:0] field,
  input  logic               size_hi,
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit
);
  logic [4:0] k;
  logic [4:0] lo;
  logic       found;
  logic       bad;
  logic       mism;

  always_comb begin
    k     = '0;
    found = 1'b0;
    for (int i = SIZE_W - 1; i >= 0; i--) begin
      if (field[i]) begin
        k     = 5'(i);
        found = 1'b1;
      end
    end
    lo   = size_hi ? (k + 5'(SIZE_W)) : k;
    bad  = 1'b0;
    mism = 1'b0;
    for (int j = 0; j < FIELD_W; j++) begin
      if (5'(j) > lo) begin
        mism = mism | (field[j] ^ addr[j + BASE_LSB]);
      end else if (size_hi && (j >= SIZE_W)) begin
        bad = bad | field[j];
      end
    end
    hit = found & ~bad & ~mism;
  end
endmodule

// File: rtl/ram_attr_resolve.sv
module ram_attr_resolve
  import ram_pkg::*;
#(
  parameter int NUM_AREAS = 4
) (
  input  logic       [NUM_AREAS-1:0] hit,
  input  area_attr_t [NUM_AREAS-1:0] attrs,
  output attr_res_t                  res
);
  attr_res_t set_acc;
  attr_res_t clr_acc;

  always_comb begin
    set_acc = '0;
    clr_acc = '0;
    for (int i = 0; i < NUM_AREAS; i++) begin
      if (hit[i] && attrs[i].enable) begin
        if (attrs[i].reverse) begin
          clr_acc = clr_acc | {attrs[i].nofreeze, attrs[i].imm, attrs[i].glb};
        end else begin
          set_acc = set_acc | {attrs[i].nofreeze, attrs[i].imm, attrs[i].glb};
        end
      end
    end
    res = set_acc & ~clr_acc;
  end
endmodule

// File: rtl/ram_desc_regs.sv
module ram_desc_regs
  import ram_pkg::*;
#(
  parameter int NUM_AREAS = 4,
  parameter int IDX_W     = $clog2(NUM_AREAS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [IDX_W:0]                    addr,
  input  logic [31:0]                       wdata,
  output logic [31:0]                       rdata,
  output logic [NUM_AREAS-1:0][FIELD_W-1:0] fields,
  output area_attr_t [NUM_AREAS-1:0]        attrs
);
  logic [NUM_AREAS-1:0][FIELD_W-1:0] fld_q, fld_d;
  area_attr_t [NUM_AREAS-1:0]        att_q, att_d;
  logic [31:0]                       rd_q, rd_d;
  logic [IDX_W-1:0]                  idx;
  logic                              idx_ok;

  assign idx    = addr[IDX_W:1];
  assign idx_ok = (int'(idx) < NUM_AREAS);

  always_comb begin
    fld_d = fld_q;
    att_d = att_q;
    if (we && idx_ok) begin
      if (addr[0]) att_d[idx] = area_attr_t'(wdata[ATTR_W-1:0]);
      else         fld_d[idx] = wdata[ADDR_W-1:BASE_LSB];
    end
    rd_d = '0;
    if (idx_ok) begin
      if (addr[0]) rd_d = {{(32-ATTR_W){1'b0}}, att_q[idx]};
      else         rd_d = {fld_q[idx], {BASE_LSB{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q <= '0;
      att_q <= '0;
    end else if (we) begin
      fld_q <= fld_d;
      att_q <= att_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rdata  = rd_q;
  assign fields = fld_q;
  assign attrs  = att_q;
endmodule

// File: rtl/region_attr_matcher.sv
module region_attr_matcher
  import ram_pkg::*;
#(
  parameter  int NUM_AREAS = 4,
  localparam int IDX_W     = $clog2(NUM_AREAS),
  localparam int REG_AW    = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              lk_valid,
  input  logic [31:0]       lk_addr,
  output logic              res_valid,
  output logic              res_glb,
  output logic              res_imm,
  output logic              res_nofreeze
);
  logic                              rst_meta, rst_sync;
  logic [NUM_AREAS-1:0][FIELD_W-1:0] fields;
  area_attr_t [NUM_AREAS-1:0]        attrs;
  logic [NUM_AREAS-1:0]              hit;
  attr_res_t                         resolved;
  attr_res_t                         res_q, res_d;
  logic                              val_q, val_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  ram_desc_regs #(.NUM_AREAS(NUM_AREAS), .IDX_W(IDX_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync),
    .we     (reg_we),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .fields (fields),
    .attrs  (attrs)
  );

  for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
    ram_area_match u_match (
      .field   (fields[g]),
      .size_hi (attrs[g].size_hi),
      .addr    (lk_addr),
      .hit     (hit[g])
    );
  end

  ram_attr_resolve #(.NUM_AREAS(NUM_AREAS)) u_resolve (
    .hit   (hit),
    .attrs (attrs),
    .res   (resolved)
  );

  always_comb begin
    res_d = lk_valid ? resolved : res_q;
    val_d = lk_valid;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      res_q <= '0;
      val_q <= 1'b0;
    end else begin
      val_q <= val_d;
      if (lk_valid) res_q <= res_d;
    end
  end

  assign res_valid    = val_q;
  assign res_glb      = res_q.glb;
  assign res_imm      = res_q.imm;
  assign res_nofreeze = res_q.nofreeze;
endmodule

// File: rtl/region_attr_matcher_chk.sv
module region_attr_matcher_chk #(
  parameter int REG_AW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              lk_valid,
  input logic              res_valid,
  input logic              res_glb,
  input logic              res_imm,
  input logic              res_nofreeze
);
  // R9
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
  // R9
  no_req_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> $stable({res_glb, res_imm, res_nofreeze}));
  // R1
  base_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_addr[0] |=> (reg_rdata[7:0] == 8'h00));
  // R11
  attr_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr[0] |=> (reg_rdata[31:6] == 26'h0));
endmodule

bind region_attr_matcher region_attr_matcher_chk #(.REG_AW(REG_AW)) i_chk (.*);

// File: tb/test_region_attr_matcher.sv
module test_region_attr_matcher;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        lk_valid;
  logic [31:0] lk_addr;
  logic        res_valid, res_glb, res_imm, res_nofreeze;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [23:0] cfg_fld [4];
  logic [5:0]  cfg_att [4];

  always #5 clk = ~clk;

  region_attr_matcher #(.NUM_AREAS(4)) i_region_attr_matcher (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .res_valid(res_valid), .res_glb(res_glb),
    .res_imm(res_imm), .res_nofreeze(res_nofreeze)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic bit model_hit(input logic [23:0] fld, input logic sb, input logic [31:0] a);
    longint base;
    longint size;
    int     k;
    int     lg;
    base = longint'(fld) * 256;
    k = -1;
    for (int i = 9; i >= 0; i--) if (fld[i]) k = i;
    if (k < 0) return 0;
    lg = 9 + k + (sb ? 10 : 0);
    size = longint'(1) << lg;
    if (sb) begin
      base = base - (base % 262144);
      if ((base % size) != 0) return 0;
    end
    return (longint'(a) / size) == (base / size);
  endfunction

  function automatic logic [2:0] model_attr(input logic [31:0] a);
    logic [2:0] s;
    logic [2:0] c;
    s = '0;
    c = '0;
    for (int i = 0; i < 4; i++) begin
      if (cfg_att[i][1] && model_hit(cfg_fld[i], cfg_att[i][0], a)) begin
        if (cfg_att[i][5]) c = c | cfg_att[i][4:2];
        else               s = s | cfg_att[i][4:2];
      end
    end
    return s & ~c;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input string req, input logic [31:0] exp);
    reg_addr = a;
    @(negedge clk);
    chk(req, reg_rdata, exp);
  endtask

  task automatic set_area(input int i, input logic [23:0] fld, input logic [5:0] att);
    wr({2'(i), 1'b0}, {fld, 8'hA5});
    wr({2'(i), 1'b1}, {26'h3FFFFFF, att});
    cfg_fld[i] = fld;
    cfg_att[i] = att;
  endtask

  task automatic look(input logic [31:0] a, input string req);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(req, {28'h0, res_valid, res_nofreeze, res_imm, res_glb}, {28'h0, 1'b1, model_attr(a)});
  endtask

  task automatic sweep(input string req, input int step, input int count, input int off);
    for (int n = 0; n < count; n++) look(32'(n * step + off), req);
  endtask

  // attribute words: [0] size-range [1] enable [2] global [3] imm [4] nofreeze [5] reverse
  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    lk_valid = 1'b0; lk_addr = '0;
    for (int i = 0; i < 4; i++) begin cfg_fld[i] = '0; cfg_att[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk("R9 reset", {31'h0, res_valid}, 32'h0);
    chk("R5 reset", {29'h0, res_nofreeze, res_imm, res_glb}, 32'h0);
    rd(3'd0, "R1 reset", 32'h0);
    look(32'h0010_0000, "R5 empty table");

    // register readback
    for (int i = 0; i < 4; i++) begin
      wr({2'(i), 1'b0}, 32'hDEAD_BE00 ^ (32'(i) << 12) ^ 32'h0000_00FF);
      wr({2'(i), 1'b1}, 32'hFFFF_FFC0 | 32'(i * 9 + 5));
    end
    for (int i = 0; i < 4; i++) begin
      rd({2'(i), 1'b0}, "R1 base readback", (32'hDEAD_BE00 ^ (32'(i) << 12)) & 32'hFFFF_FF00);
      rd({2'(i), 1'b1}, "R11 attr readback", 32'(i * 9 + 5) & 32'h3F);
    end
    for (int i = 0; i < 4; i++) set_area(i, 24'h0, 6'h0);

    // worked example: 256 KB at 1 MB, immediate
    set_area(0, 24'h001200, 6'b001010);
    rd(3'd0, "R2 example field", 32'h0012_0000);
    look(32'h0010_0000, "R2 first byte");
    chk("R2 first byte imm", {31'h0, res_imm}, 32'h1);
    look(32'h0013_FFFF, "R2 last byte");
    chk("R2 last byte imm", {31'h0, res_imm}, 32'h1);
    look(32'h0014_0000, "R2 past end");
    chk("R2 past end imm", {31'h0, res_imm}, 32'h0);
    look(32'h000F_FFFF, "R2 before start");
    chk("R2 before start imm", {31'h0, res_imm}, 32'h0);

    // R9 hold: idle cycles keep the result, valid low
    look(32'h0010_0040, "R9 setup");
    repeat (3) @(negedge clk);
    chk("R9 hold valid", {31'h0, res_valid}, 32'h0);
    chk("R9 hold attr", {29'h0, res_nofreeze, res_imm, res_glb}, 32'h2);

    // nested: 2 MB imm+glb, reverse imm hole at 1 MB/256 KB, 64 KB nofreeze
    set_area(0, 24'h000004, 6'b001111);
    set_area(1, 24'h001200, 6'b101010);
    set_area(2, 24'h001880, 6'b010010);
    set_area(3, 24'h000200, 6'b011100);
    look(32'h0012_0000, "R7 hole keeps global");
    chk("R7 hole imm", {30'h0, res_imm, res_glb}, 32'h1);
    look(32'h0018_0000, "R8 nofreeze alone");
    sweep("R7 nested sweep", 32'h1000, 1024, 0);
    sweep("R8 nested sweep", 32'h1000, 1024, 32'hFFF);

    // size-range, unsupported encodings, overlap OR
    set_area(0, 24'h002002, 6'b000111);
    set_area(1, 24'h002600, 6'b001110);
    set_area(2, 24'h000401, 6'b011011);
    set_area(3, 24'h003000, 6'b010010);
    look(32'h0024_0000, "R6 overlap global and imm");
    chk("R6 overlap bits", {29'h0, res_nofreeze, res_imm, res_glb}, 32'h3);
    look(32'h0000_0000, "R4 unaligned area");
    chk("R4 unaligned bits", {29'h0, res_nofreeze, res_imm, res_glb}, 32'h0);
    look(32'h0030_0000, "R4 no marker");
    chk("R4 no marker bits", {29'h0, res_nofreeze, res_imm, res_glb}, 32'h0);
    look(32'h002F_FFFF, "R3 large area end");
    chk("R3 large area glb", {31'h0, res_glb}, 32'h1);
    sweep("R3 range sweep", 32'h1000, 1024, 0);
    sweep("R6 range sweep", 32'h1000, 1024, 32'hFFF);

    // disabled areas
    set_area(0, 24'h000004, 6'b001101);
    set_area(1, 24'h001200, 6'b011100);
    set_area(2, 24'h001880, 6'b010000);
    set_area(3, 24'h000200, 6'b011100);
    sweep("R5 disabled sweep", 32'h4000, 256, 0);

    // R10: write and lookup in the same cycle
    set_area(0, 24'h000200, 6'b001000);
    reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h0000_000A;
    lk_valid = 1'b1; lk_addr = 32'h0000_0100;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R10 same-cycle old", {29'h0, res_nofreeze, res_imm, res_glb}, 32'h0);
    cfg_att[0] = 6'b001010;
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R10 next-cycle new", {29'h0, res_nofreeze, res_imm, res_glb}, 32'h2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule